// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block produces the address of the next microinstruction for a microprogrammed control unit. Every cycle it reads the condition, branch-type and address fields of the microinstruction now being executed. It also reads three status flags from the datapath: the indirect-address bit, the accumulator sign and the accumulator-zero flag. The fourth input is the 4-bit opcode of the machine instruction. From these it chooses the value that the control address register takes at the next clock edge.

The condition field picks one test bit. The branch-type field sets two multiplexer select lines and a load enable for a one-entry return-address register. Together they give five kinds of sequencing:

- falling through to the next address;
- a conditional jump;
- a conditional call that saves the return address;
- a return;
- a dispatch from the opcode to its routine entry point.

A synchronous reset starts execution at the fetch routine. A stall input holds the sequencer while slow memory completes.

Top module: `microseq`

## Requirements
- R1: While `rst` is high at a clock edge, the control address becomes 64 (binary 1000000) and the return register becomes 0.
- R2: The condition field selects the test bit T: 00 gives constant 1, 01 gives `ind_bit`, 10 gives `acc_sign`, 11 gives `acc_zero`.
- R3: Branch type 00 (jump) loads the address field when T is 1. When T is 0 it loads the current address plus one.
- R4: Branch type 01 (call) with T equal to 1 loads the address field and stores the current address plus one in the return register. With T equal to 0 it loads the current address plus one and leaves the return register unchanged.
- R5: Branch type 10 (return) loads the return register into the control address, whatever the value of T.
- R6: Branch type 11 (map) loads {0, opcode, 00}, so the entry points are 0, 4, 8 and so on up to 60, whatever the value of T.
- R7: The incremented address wraps modulo 128, so 127 is followed by 0.
- R8: When `stall` is high at a clock edge and `rst` is low, neither the control address nor the return register changes.
- R9: The return register changes only on a call whose test bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Hold both registers this cycle |
| cond_code | input | 2 | Condition field of the current microinstruction |
| br_code | input | 2 | Branch-type field of the current microinstruction |
| addr_field | input | 7 | Address field of the current microinstruction |
| ind_bit | input | 1 | Indirect-address bit of the machine instruction |
| acc_sign | input | 1 | Accumulator sign flag |
| acc_zero | input | 1 | Accumulator zero flag |
| opcode | input | 4 | Machine instruction opcode |
| car | output | 7 | Control address register |
| sbr | output | 7 | Subroutine return register |

## Verification
The hardest state to reach is a return whose target was saved many cycles earlier. Before the return arrives, the return register must have survived a call with a false condition, a stall, several jumps and a map. The stimulus therefore places a taken call first, then a call with a false condition and a stalled cycle, and only then issues a return whose own test bit is 0. A second run of the same sequence drives the address to 127 and lets a false jump wrap it to 0. A reset in the middle of the run checks that the reset state is restored after real traffic.

// File: rtl/microseq_pkg.sv
package microseq_pkg;
  typedef enum logic [1:0] {
    CD_ALWAYS = 2'b00,
    CD_IND    = 2'b01,
    CD_SIGN   = 2'b10,
    CD_ZERO   = 2'b11
  } cond_e;

  typedef enum logic [1:0] {
    BR_JMP  = 2'b00,
    BR_CALL = 2'b01,
    BR_RET  = 2'b10,
    BR_MAP  = 2'b11
  } branch_e;

  typedef enum logic [1:0] {
    SRC_INC   = 2'b00,
    SRC_FIELD = 2'b01,
    SRC_SBR   = 2'b10,
    SRC_MAP   = 2'b11
  } src_e;
endpackage

// File: rtl/microseq_cond_sel.sv
module microseq_cond_sel #(
  parameter int N_COND = 4
) (
  input  logic [$clog2(N_COND)-1:0] cond_code,
  input  logic                      ind_bit,
  input  logic                      acc_sign,
  input  logic                      acc_zero,
  output logic                      test
);
  logic [N_COND-1:0] cands;

  always_comb begin
    cands = '0;
    cands[microseq_pkg::CD_ALWAYS] = 1'b1;
    cands[microseq_pkg::CD_IND]    = ind_bit;
    cands[microseq_pkg::CD_SIGN]   = acc_sign;
    cands[microseq_pkg::CD_ZERO]   = acc_zero;
    test = cands[cond_code];
  end
endmodule

// File: rtl/microseq_sel_logic.sv
module microseq_sel_logic (
  input  logic [1:0] br_code,
  input  logic       test,
  output logic [1:0] src_sel,
  output logic       load_sbr
);
  logic i1, i0;

  assign i1       = br_code[1];
  assign i0       = br_code[0];
  assign src_sel  = {i1, (i0 & i1) | (~i1 & test)};
  assign load_sbr = ~i1 & i0 & test;
endmodule

// File: rtl/microseq_addr_mux.sv
module microseq_addr_mux #(
  parameter int AW      = 7,
  parameter int OPW     = 4,
  parameter int MAP_LSB = 2
) (
  input  logic [1:0]     src_sel,
  input  logic [AW-1:0]  car_q,
  input  logic [AW-1:0]  sbr_q,
  input  logic [AW-1:0]  addr_field,
  input  logic [OPW-1:0] opcode,
  output logic [AW-1:0]  car_inc,
  output logic [AW-1:0]  car_next
);
  import microseq_pkg::*;

  logic [AW-1:0] mapped;

  assign car_inc = car_q + AW'(1);

  generate
    if (OPW + MAP_LSB < AW) begin : g_pad
      assign mapped = {{(AW-OPW-MAP_LSB){1'b0}}, opcode, {MAP_LSB{1'b0}}};
    end else begin : g_nopad
      assign mapped = AW'({opcode, {MAP_LSB{1'b0}}});
    end
  endgenerate

  always_comb begin
    unique case (src_e'(src_sel))
      SRC_INC:   car_next = car_inc;
      SRC_FIELD: car_next = addr_field;
      SRC_SBR:   car_next = sbr_q;
      SRC_MAP:   car_next = mapped;
      default:   car_next = car_inc;
    endcase
  end
endmodule

// File: rtl/microseq.sv
module microseq #(
  parameter int AW         = 7,
  parameter int OPW        = 4,
  parameter int MAP_LSB    = 2,
  parameter int FETCH_ADDR = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           stall,
  input  logic [1:0]     cond_code,
  input  logic [1:0]     br_code,
  input  logic [AW-1:0]  addr_field,
  input  logic           ind_bit,
  input  logic           acc_sign,
  input  logic           acc_zero,
  input  logic [OPW-1:0] opcode,
  output logic [AW-1:0]  car,
  output logic [AW-1:0]  sbr
);
  import microseq_pkg::*;

  localparam logic [AW-1:0] RESET_CAR = AW'(FETCH_ADDR);

  logic          test;
  logic [1:0]    src_sel;
  logic          load_sbr;
  logic [AW-1:0] car_inc;
  logic [AW-1:0] car_next;

  microseq_cond_sel #(.N_COND(4)) i_cond (
    .cond_code (cond_code),
    .ind_bit   (ind_bit),
    .acc_sign  (acc_sign),
    .acc_zero  (acc_zero),
    .test      (test)
  );

  microseq_sel_logic i_sel (
    .br_code  (br_code),
    .test     (test),
    .src_sel  (src_sel),
    .load_sbr (load_sbr)
  );

  microseq_addr_mux #(.AW(AW), .OPW(OPW), .MAP_LSB(MAP_LSB)) i_mux (
    .src_sel    (src_sel),
    .car_q      (car),
    .sbr_q      (sbr),
    .addr_field (addr_field),
    .opcode     (opcode),
    .car_inc    (car_inc),
    .car_next   (car_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      car <= RESET_CAR;
      sbr <= '0;
    end else if (!stall) begin
      car <= car_next;
      if (load_sbr) sbr <= car_inc;
    end
  end

  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (car == RESET_CAR && sbr == '0));

  // R8
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (rst)
    stall |=> ($stable(car) && $stable(sbr)));

  // R5
  a_r5_return: assert property (@(posedge clk) disable iff (rst)
    (!stall && br_code == BR_RET) |=> car == $past(sbr));

  // R6
  a_r6_map: assert property (@(posedge clk) disable iff (rst)
    (!stall && br_code == BR_MAP) |=>
      car == AW'({$past(opcode), {MAP_LSB{1'b0}}}));

  // R9
  a_r9_sbr_only_call: assert property (@(posedge clk) disable iff (rst)
    (br_code != BR_CALL) |=> $stable(sbr));

  // R2 / R3: an unconditional jump always lands on the address field
  a_r3_uncond_jump: assert property (@(posedge clk) disable iff (rst)
    (!stall && br_code == BR_JMP && cond_code == CD_ALWAYS) |=>
      car == $past(addr_field));

  // R7: a false jump steps by one modulo 2**AW
  a_r7_step_wrap: assert property (@(posedge clk) disable iff (rst)
    (!stall && br_code == BR_JMP && cond_code == CD_IND && !ind_bit) |=>
      car == AW'($past(car) + AW'(1)));
endmodule

// File: tb/test_microseq.sv
`timescale 1ns/1ps
module test_microseq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       stall = 1'b0;
  logic [1:0] cond_code = 2'b00;
  logic [1:0] br_code = 2'b00;
  logic [6:0] addr_field = '0;
  logic       ind_bit = 1'b0;
  logic       acc_sign = 1'b0;
  logic       acc_zero = 1'b0;
  logic [3:0] opcode = '0;
  logic [6:0] car, sbr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [6:0] car;
    logic [6:0] sbr;
    string      tag;
  } exp_t;
  exp_t q[$];

  logic [6:0] m_car, m_sbr;

  always #2.5 clk = ~clk;

  microseq i_microseq (
    .clk(clk), .rst(rst), .stall(stall), .cond_code(cond_code),
    .br_code(br_code), .addr_field(addr_field), .ind_bit(ind_bit),
    .acc_sign(acc_sign), .acc_zero(acc_zero), .opcode(opcode),
    .car(car), .sbr(sbr)
  );

  task automatic check(string tag, logic [6:0] act_c, logic [6:0] exp_c,
                       logic [6:0] act_s, logic [6:0] exp_s);
    checks++;
    if (act_c !== exp_c || act_s !== exp_s) begin
      errors++;
      $display("FAIL %s: car=%0d sbr=%0d expected car=%0d sbr=%0d",
               tag, act_c, act_s, exp_c, exp_s);
    end
  endtask

  // monitor: compare one expected item after each edge that has one pending
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, car, e.car, sbr, e.sbr);
    end
  end

  // driver: apply one microinstruction and push the predicted result
  task automatic step(logic [1:0] br, logic [1:0] cd, logic [6:0] ad,
                      logic i, logic s, logic z, logic [3:0] op,
                      logic stl, string tag);
    logic t;
    exp_t e;
    @(negedge clk);
    br_code = br; cond_code = cd; addr_field = ad;
    ind_bit = i; acc_sign = s; acc_zero = z; opcode = op; stall = stl;
    case (cd) // R2: 00 one, 01 indirect, 10 sign, 11 zero
      2'b00: t = 1'b1;
      2'b01: t = i;
      2'b10: t = s;
      default: t = z;
    endcase
    if (!stl) begin
      case (br)
        2'b00: m_car = t ? ad : m_car + 7'd1;
        2'b01: begin
          if (t) begin m_sbr = m_car + 7'd1; m_car = ad; end
          else m_car = m_car + 7'd1;
        end
        2'b10: m_car = m_sbr;
        default: m_car = {1'b0, op, 2'b00};
      endcase
    end
    e.car = m_car; e.sbr = m_sbr; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R1 reset", car, 7'd64, sbr, 7'd0);
    @(negedge clk);
    rst = 1'b0;
    m_car = 7'd64; m_sbr = 7'd0;
  endtask

  task automatic run_program();
    step(2'b00, 2'b00, 7'd10, 0, 0, 0, 0, 0, "R3 jump uncond");
    step(2'b00, 2'b01, 7'd99, 0, 0, 0, 0, 0, "R2 R3 jump I false");
    step(2'b00, 2'b01, 7'd20, 1, 0, 0, 0, 0, "R2 jump I true");
    step(2'b00, 2'b10, 7'd30, 0, 1, 0, 0, 0, "R2 jump S true");
    step(2'b00, 2'b10, 7'd77, 0, 0, 0, 0, 0, "R2 jump S false");
    step(2'b00, 2'b11, 7'd40, 0, 0, 1, 0, 0, "R2 jump Z true");
    step(2'b00, 2'b11, 7'd88, 0, 0, 0, 0, 0, "R2 jump Z false");
    step(2'b01, 2'b00, 7'd100, 0, 0, 0, 0, 0, "R4 call taken");
    step(2'b01, 2'b01, 7'd5, 0, 0, 0, 0, 0, "R4 R9 call false");
    step(2'b00, 2'b00, 7'd5, 0, 0, 0, 0, 1, "R8 stall");
    step(2'b01, 2'b00, 7'd9, 0, 0, 0, 0, 1, "R8 stall call");
    step(2'b11, 2'b10, 7'd3, 0, 0, 0, 4'hf, 0, "R6 map op15 T0");
    step(2'b00, 2'b00, 7'd50, 0, 0, 0, 0, 0, "R9 jump keeps sbr");
    step(2'b10, 2'b11, 7'd7, 0, 0, 0, 0, 0, "R5 return T0");
    step(2'b11, 2'b00, 7'd3, 0, 0, 0, 4'h3, 0, "R6 map op3");
    step(2'b11, 2'b00, 7'd3, 0, 0, 0, 4'h0, 0, "R6 map op0");
    step(2'b00, 2'b00, 7'd127, 0, 0, 0, 0, 0, "R3 jump to 127");
    step(2'b00, 2'b01, 7'd12, 0, 0, 0, 0, 0, "R7 wrap");
    step(2'b01, 2'b11, 7'd126, 0, 0, 1, 0, 0, "R4 call Z taken");
    step(2'b00, 2'b00, 7'd127, 0, 0, 0, 0, 0, "R3 jump to 127 again");
    step(2'b01, 2'b00, 7'd60, 0, 0, 0, 0, 0, "R4 R7 call from 127");
    step(2'b10, 2'b00, 7'd1, 0, 0, 0, 0, 0, "R5 return to 0");
    @(negedge clk);
    stall = 1'b0; br_code = 2'b00; cond_code = 2'b01; ind_bit = 1'b0;
    @(posedge clk); #2;
  endtask

  initial begin
    m_car = 7'd64; m_sbr = 7'd0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset initial", car, 7'd64, sbr, 7'd0);
    @(negedge clk);
    rst = 1'b0;
    run_program();
    do_reset();
    run_program();
    while (q.size() > 0) @(posedge clk);
    #2;
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule